// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken. A global register holds the outcomes of the most recent branches, whichever branches they were. The value of that register picks one of several pattern tables. The low bits of the branch address then pick one saturating counter inside that table. Because the recent global outcomes choose the table, the same branch can be given different predictions depending on how its neighbours went.

The lookup side is purely combinational. It takes an address and returns the prediction together with the history value it used. The front end keeps that history value alongside the branch. When the branch resolves, the update side gets the address, the saved history and the real outcome. The addressed counter steps once toward that outcome. The outcome is also shifted into the global history.

Parameters set the history length, the number of address index bits and the counter width. A history length of zero turns the block into a single table that is indexed by address alone.

Top module: `corr_gap_predictor`

## Requirements
- R1: After reset the history reads zero and every counter sits one step below the taken threshold (value 2^(CTR_BITS-1)-1, i.e. 01 for two-bit counters), so every lookup predicts not taken (lk_taken=0).
- R2: lk_taken is the most significant bit of the counter in table lk_hist at entry lk_addr[IDX_BITS-1:0] (1 = taken); address bits above IDX_BITS have no effect.
- R3: An update with up_taken=1 raises the addressed counter by one, holding at 2^CTR_BITS-1.
- R4: An update with up_taken=0 lowers the addressed counter by one, holding at 0.
- R5: Each update shifts up_taken into bit 0 of the history; the older bits move up one place and the oldest bit is dropped. lk_hist shows the current history.
- R6: An update selects its table with the supplied up_hist and not with the current history.
- R7: A lookup made in the same cycle as an update sees the counters and history from before that update.
- R8: With up_valid low, no counter and no history bit changes.
- R9: With HIST_LEN=0 there is one table, indexed by address only, and lk_hist stays 0.
- R10: On a stream where branch C is taken exactly when both preceding branches A and B were not taken, the prediction for C is always right after warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_addr | input | ADDR_W | Address of the branch being looked up |
| lk_taken | output | 1 | Prediction: 1 taken, 0 not taken |
| lk_hist | output | max(HIST_LEN,1) | History used by this lookup; to be returned on update |
| up_valid | input | 1 | Update strobe |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_hist | input | max(HIST_LEN,1) | History captured when this branch was predicted |
| up_taken | input | 1 | Resolved outcome |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. The first uses two history bits, four index bits and two-bit counters, which gives four tables of sixteen entries. With two history bits the three-branch correlated pattern can be learned fully, and updates can point at a table other than the current one. The second uses no history, four index bits and three-bit counters. It covers the single-table variant and the reset value and saturation limits of a wider counter.

// File: rtl/gap_pkg.sv
package gap_pkg;

    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;

    function automatic int hist_width(input int len);
        return (len < 1) ? 1 : len;
    endfunction

endpackage

// File: rtl/gap_sat_cell.sv
module gap_sat_cell #(
    parameter int CTR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  gap_pkg::dir_e       dir,
    output logic [CTR_BITS-1:0] q
);
    localparam logic [CTR_BITS-1:0] TOP  = {CTR_BITS{1'b1}};
    localparam logic [CTR_BITS-1:0] INIT = TOP >> 1;

    logic [CTR_BITS-1:0] q_nxt;

    always_comb begin
        q_nxt = q;
        if (en) begin
            unique case (dir)
                gap_pkg::DIR_TAKEN:     if (q != TOP)          q_nxt = q + 1'b1;
                gap_pkg::DIR_NOT_TAKEN: if (q != '0)           q_nxt = q - 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else        q <= q_nxt;
    end
endmodule

// File: rtl/gap_global_hist.sv
module gap_global_hist #(
    parameter int HIST_LEN = 2,
    parameter int HW       = gap_pkg::hist_width(HIST_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HW-1:0] hist
);
    generate
        if (HIST_LEN == 0) begin : g_none
            logic unused_hist_in;
            assign unused_hist_in = &{1'b0, clk, rst_n, shift_en, bit_in};
            assign hist = '0;
        end else if (HIST_LEN == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= bit_in;
            end
        end else begin : g_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist <= '0;
                else if (shift_en) hist <= {hist[HW-2:0], bit_in};
            end
        end
    endgenerate
endmodule

// File: rtl/gap_pattern_bank.sv
module gap_pattern_bank #(
    parameter int HIST_LEN = 2,
    parameter int IDX_BITS = 4,
    parameter int CTR_BITS = 2,
    parameter int HW       = gap_pkg::hist_width(HIST_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HW-1:0]       rd_tbl,
    input  logic [IDX_BITS-1:0] rd_idx,
    input  logic                wr_en,
    input  logic [HW-1:0]       wr_tbl,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  gap_pkg::dir_e       wr_dir,
    output logic [CTR_BITS-1:0] rd_cnt,
    output logic [CTR_BITS-1:0] wr_cnt
);
    localparam int SEL_W = HIST_LEN + IDX_BITS;
    localparam int CELLS = 1 << SEL_W;

    logic [SEL_W-1:0]    rd_sel, wr_sel;
    logic [CTR_BITS-1:0] cell_q [CELLS];

    generate
        if (HIST_LEN == 0) begin : g_flat
            logic unused_tbl;
            assign unused_tbl = &{1'b0, rd_tbl, wr_tbl};
            assign rd_sel = rd_idx;
            assign wr_sel = wr_idx;
        end else begin : g_split
            assign rd_sel = {rd_tbl, rd_idx};
            assign wr_sel = {wr_tbl, wr_idx};
        end

        for (genvar c = 0; c < CELLS; c++) begin : g_cell
            gap_sat_cell #(.CTR_BITS(CTR_BITS)) u_cell (
                .clk  (clk),
                .rst_n(rst_n),
                .en   (wr_en && (wr_sel == SEL_W'(c))),
                .dir  (wr_dir),
                .q    (cell_q[c])
            );
        end
    endgenerate

    assign rd_cnt = cell_q[rd_sel];
    assign wr_cnt = cell_q[wr_sel];
endmodule

// File: rtl/corr_gap_predictor.sv
module corr_gap_predictor #(
    parameter int HIST_LEN = 2,
    parameter int IDX_BITS = 4,
    parameter int CTR_BITS = 2,
    parameter int ADDR_W   = 32,
    parameter int HW       = gap_pkg::hist_width(HIST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_taken,
    output logic [HW-1:0]     lk_hist,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [HW-1:0]     up_hist,
    input  logic              up_taken
);
    logic [CTR_BITS-1:0] rd_cnt;
    logic [CTR_BITS-1:0] upd_cnt;
    gap_pkg::dir_e       up_dir;

    assign up_dir = up_taken ? gap_pkg::DIR_TAKEN : gap_pkg::DIR_NOT_TAKEN;

    generate
        if (ADDR_W > IDX_BITS) begin : g_hi
            logic unused_addr_hi;
            assign unused_addr_hi = &{1'b0, lk_addr[ADDR_W-1:IDX_BITS],
                                      up_addr[ADDR_W-1:IDX_BITS]};
        end
    endgenerate

    gap_global_hist #(.HIST_LEN(HIST_LEN), .HW(HW)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(up_valid),
        .bit_in  (up_taken),
        .hist    (lk_hist)
    );

    gap_pattern_bank #(
        .HIST_LEN(HIST_LEN), .IDX_BITS(IDX_BITS), .CTR_BITS(CTR_BITS), .HW(HW)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_tbl(lk_hist),
        .rd_idx(lk_addr[IDX_BITS-1:0]),
        .wr_en (up_valid),
        .wr_tbl(up_hist),
        .wr_idx(up_addr[IDX_BITS-1:0]),
        .wr_dir(up_dir),
        .rd_cnt(rd_cnt),
        .wr_cnt(upd_cnt)
    );

    assign lk_taken = rd_cnt[CTR_BITS-1];
endmodule

// File: rtl/gap_checker.sv
module gap_checker #(
    parameter int HIST_LEN = 2,
    parameter int IDX_BITS = 4,
    parameter int CTR_BITS = 2,
    parameter int ADDR_W   = 32,
    parameter int HW       = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   lk_addr,
    input logic                lk_taken,
    input logic [HW-1:0]       lk_hist,
    input logic                up_valid,
    input logic [ADDR_W-1:0]   up_addr,
    input logic [HW-1:0]       up_hist,
    input logic                up_taken,
    input logic [CTR_BITS-1:0] upd_cnt
);
    localparam logic [CTR_BITS-1:0] TOP = {CTR_BITS{1'b1}};

    // R8: idle cycles leave the history alone
    p_hist_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    // R8: idle cycle with a steady lookup address keeps the prediction
    p_pred_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> ($stable(lk_addr) -> $stable(lk_taken)));

    // R3: a saturated counter taking another taken stays saturated
    p_top_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(up_valid) && $past(up_taken)
         && up_addr[IDX_BITS-1:0] == $past(up_addr[IDX_BITS-1:0])
         && up_hist == $past(up_hist) && $past(upd_cnt) == TOP)
        |-> upd_cnt == TOP);

    // R4: an empty counter taking another not-taken stays empty
    p_floor_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(up_valid) && !$past(up_taken)
         && up_addr[IDX_BITS-1:0] == $past(up_addr[IDX_BITS-1:0])
         && up_hist == $past(up_hist) && $past(upd_cnt) == '0)
        |-> upd_cnt == '0);

    generate
        if (HIST_LEN >= 2) begin : g_sh
            // R5: outcome enters at bit 0, the rest move up
            p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> lk_hist == {$past(lk_hist[HW-2:0]), $past(up_taken)});
        end else if (HIST_LEN == 1) begin : g_sh1
            p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> lk_hist == $past(up_taken));
        end else begin : g_flat
            // R9: no history in the flat variant
            p_flat_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
                lk_hist == '0);
        end
    endgenerate
endmodule

bind corr_gap_predictor gap_checker #(
    .HIST_LEN(HIST_LEN), .IDX_BITS(IDX_BITS), .CTR_BITS(CTR_BITS),
    .ADDR_W(ADDR_W), .HW(HW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .up_valid(up_valid), .up_addr(up_addr),
    .up_hist(up_hist), .up_taken(up_taken), .upd_cnt(upd_cnt)
);

// File: tb/corr_gap_predictor_tb.sv
module corr_gap_predictor_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr = '0, up_addr = '0;
    logic        up_valid = 1'b0, up_taken = 1'b0;
    logic [1:0]  up_hist = '0;
    logic        lk_taken_a, lk_taken_b;
    logic [1:0]  lk_hist_a;
    logic [0:0]  lk_hist_b;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    int mdl_a [4][16];
    int mdl_b [16];
    logic [1:0] hist_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    corr_gap_predictor #(.HIST_LEN(2), .IDX_BITS(4), .CTR_BITS(2), .ADDR_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken_a),
        .lk_hist(lk_hist_a), .up_valid(up_valid), .up_addr(up_addr),
        .up_hist(up_hist), .up_taken(up_taken));

    corr_gap_predictor #(.HIST_LEN(0), .IDX_BITS(4), .CTR_BITS(3), .ADDR_W(32)) u_dut_m0 (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken_b),
        .lk_hist(lk_hist_b), .up_valid(up_valid), .up_addr(up_addr),
        .up_hist(1'b0), .up_taken(up_taken));

    function automatic int sat(int v, bit t, int top);
        if (t) return (v < top) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction

    task automatic chk(int act, int exp, string tag, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // drive at negedge, sample 1 time unit later (before the update edge)
    task automatic step(logic [31:0] a, bit v, bit t, logic [1:0] uh, string tag);
        @(negedge clk);
        lk_addr = a; up_addr = a; up_valid = v; up_taken = t; up_hist = uh;
        #1;
        chk(int'(lk_taken_a), int'(mdl_a[hist_m][a[3:0]] >= 2), tag, "R2 prediction");
        chk(int'(lk_hist_a), int'(hist_m), tag, "R5 history");
        chk(int'(lk_taken_b), int'(mdl_b[a[3:0]] >= 4), tag, "R9 flat prediction");
        chk(int'(lk_hist_b), 0, tag, "R9 flat history");
        if (v) begin
            mdl_a[uh][a[3:0]] = sat(mdl_a[uh][a[3:0]], t, 3);
            mdl_b[a[3:0]]     = sat(mdl_b[a[3:0]], t, 7);
            hist_m = {hist_m[0], t};
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 4; i++) for (int j = 0; j < 16; j++) mdl_a[i][j] = 1;
        for (int j = 0; j < 16; j++) mdl_b[j] = 3;
        hist_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing predicted taken
        for (int j = 0; j < 16; j++) step(32'(j), 0, 0, 2'b00, "R1");
        chk(int'(lk_taken_a), 0, "R1", "reset prediction");

        // R3 / R6: train table 0 at index 5 while history wanders
        for (int k = 0; k < 6; k++) step(32'h5, 1, 1, 2'b00, "R3");
        // R4: drain the same counter past zero
        for (int k = 0; k < 6; k++) step(32'h5, 1, 0, 2'b00, "R4");
        // R6: updates aimed at table 3 regardless of current history
        for (int k = 0; k < 3; k++) step(32'h9, 1, 1, 2'b11, "R6");
        for (int k = 0; k < 2; k++) step(32'h9, 1, 1, 2'b11, "R6");
        step(32'h9, 0, 0, 2'b00, "R6");
        // R2: upper address bits alias onto the same entry
        step(32'hFFFF_FFF9, 0, 0, 2'b00, "R2");
        step(32'h1234_5679, 0, 1, 2'b00, "R2");
        // R8: idle cycles with the outcome line toggling
        for (int k = 0; k < 8; k++) step(32'(k), 0, k[0], 2'(k), "R8");

        // R7: random mix; every update cycle also checks the pre-update lookup
        for (int k = 0; k < 1500; k++) begin
            logic [31:0] a;
            bit v, t;
            a = $urandom;
            v = ($urandom % 4) != 0;
            t = $urandom % 2;
            step(a, v, t, ((($urandom % 8) == 0) ? 2'($urandom) : hist_m), "R7");
        end

        // R10: C taken exactly when A and B both not taken
        begin
            int miss;
            miss = 0;
            for (int it = 0; it < 200; it++) begin
                bit oa, ob, oc;
                oa = $urandom % 2;
                ob = $urandom % 2;
                oc = !(oa || ob);
                step(32'h11, 1, oa, hist_m, "R10");
                step(32'h22, 1, ob, hist_m, "R10");
                @(negedge clk);
                lk_addr = 32'h33; up_valid = 1'b0;
                #1;
                if (it >= 60 && lk_taken_a != oc) miss++;
                step(32'h33, 1, oc, hist_m, "R10");
            end
            chk(miss, 0, "R10", "mispredictions after warm-up");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule